// File: doc/BRIEF.md
# Register-Driven Serial Flash Shifter

This block lets software run a serial NOR flash one command at a time through a small 32-bit register bus. Software drives the two active-low chip selects and a 2-bit byte-count field in a control word. Each access to the data register then moves 1 to 4 bytes over a single-bit serial link in clock mode 0. The serial clock idles low, the outgoing bit changes on the falling edge and the incoming bit is sampled on the rising edge.

Chip select stays where software last put it. An opcode, its address, a dummy byte and the payload can therefore be issued as separate data-register accesses that the flash sees as one unbroken transaction. A data-register read stalls the bus response until its receive burst has finished, then returns the received bytes left-aligned. The configuration word holds a serial clock divider and a chip-select settle count. While that count runs after a select change, the block is not ready.

Top module: `spi_flash_shifter`

## Requirements
- R1: After reset, chip selects are high, the serial clock is low, the control word reads 0xC800_0000, and both configuration words read zero.
- R2: Register word select `addr_i`: 0 is the configuration word (divider in bits 31:29, settle count in bits 26:23), 1 is a general 32-bit configuration word, 2 is the control word, 3 is data. A read of words 0–2 returns with `rvalid_o` in the cycle after the request. Control bits 26:25 (I/O width, 0 = single bit) are stored and read back.
- R3: Control bit 31 drives `cs_no[0]` and bit 30 drives `cs_no[1]`, both active low. They hold their value until the control word is written again.
- R4: A data write sends (bits 29:28 + 1) bytes on `mosi_o`, most significant bit first, starting at data bit 31. Each bit is stable while the serial clock is high.
- R5: Each serial clock phase lasts (divider + 1) system clock cycles.
- R6: A data read while ready and with a chip select low clocks in (len + 1) bytes while holding `mosi_o` at 0. `rvalid_o` is raised after the burst, with the received bits left-aligned from bit 31 and unused low bits at zero.
- R7: Control bit 27 (ready) reads 0 from the cycle after a burst is accepted until the burst ends, and reads 1 when idle.
- R8: A control write that changes either select bit loads the settle count. Ready is 0 until that many cycles have passed.
- R9: Writes of any register while ready is 0 are ignored.
- R10: A data read with both selects high, or while not ready, returns the last received word in the next cycle and produces no serial clock.
- R11: With chip select held low, successive accesses form one contiguous bit stream at the flash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register word select (byte offset bits 3:2) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |
| cs_no | output | 2 | Chip selects, active low |

## Verification
The assertions assume that the host keeps at most one read outstanding and issues no request while a data-read burst is pending. The stimulus respects this by waiting for `rvalid_o` after every read before issuing the next access. Everything else is checked against a behavioural flash that samples `mosi_o` on rising serial clock edges and feeds a 64-bit pattern back on `miso_i`. Random lengths, dividers, payloads and patterns are mixed with directed cases: a chained command/address/data transaction, accesses made during a burst, accesses made during the settle window, and reads with no device selected.

// File: rtl/spi_shf_pkg.sv
package spi_shf_pkg;
  parameter int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_CFG2 = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  localparam int unsigned CS0_BIT = 31;
  localparam int unsigned CS1_BIT = 30;
  localparam int unsigned LEN_LSB = 28;
  localparam int unsigned RDY_BIT = 27;
  localparam int unsigned IOW_LSB = 25;
  localparam int unsigned IOW_W   = 2;
  localparam int unsigned DIV_LSB = 29;
  localparam int unsigned GAP_LSB = 23;
endpackage

// File: rtl/spi_shf_gap.sv
module spi_shf_gap #(
  parameter int unsigned GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] val_i,
  output logic             idle_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/spi_shf_engine.sv
module spi_shf_engine #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DIV_W  = 3,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_o
);
  localparam int unsigned CNT_W = LEN_W + 4;
  localparam int unsigned SH_W  = LEN_W + 3;

  logic              busy_q, sclk_q, done_q, rd_q;
  logic [DIV_W-1:0]  div_cnt_q;
  logic [CNT_W-1:0]  bits_q;
  logic [LEN_W-1:0]  len_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q, rx_word_q;
  logic [CNT_W-1:0]  nbits;
  logic [SH_W-1:0]   shamt;

  // bits in burst = (len+1)*8; left-align shift = (max_len-len)*8
  assign nbits = {({1'b0, len_i} + 1'b1), 3'b000};
  assign shamt = {~len_q, 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      sclk_q    <= 1'b0;
      done_q    <= 1'b0;
      rd_q      <= 1'b0;
      div_cnt_q <= '0;
      bits_q    <= '0;
      len_q     <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_word_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q    <= 1'b1;
          sclk_q    <= 1'b0;
          div_cnt_q <= '0;
          bits_q    <= nbits;
          len_q     <= len_i;
          rd_q      <= rd_i;
          tx_sh_q   <= tx_i;
          rx_sh_q   <= '0;
        end
      end else if (div_cnt_q == div_i) begin
        div_cnt_q <= '0;
        sclk_q    <= ~sclk_q;
        if (!sclk_q) begin
          rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
        end else begin
          tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
          bits_q  <= bits_q - 1'b1;
          if (bits_q == CNT_W'(1)) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b1;
            rx_word_q <= rx_sh_q << shamt;
          end
        end
      end else begin
        div_cnt_q <= div_cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sclk_o = sclk_q;
  assign mosi_o = busy_q & tx_sh_q[WORD_W-1];
  assign rx_o   = rx_word_q;

  p_sclk_idle_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
  p_mosi_hold_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && sclk_q) |-> $stable(mosi_o));
  p_rd_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rd_q) |-> !mosi_o);
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: rtl/spi_shf_regs.sv
module spi_shf_regs
  import spi_shf_pkg::*;
#(
  parameter int unsigned DIV_W = 3,
  parameter int unsigned GAP_W = 4,
  parameter int unsigned LEN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              ready_i,
  input  logic              eng_done_i,
  input  logic [WORD_W-1:0] eng_rx_i,
  output logic              start_o,
  output logic              start_rd_o,
  output logic [WORD_W-1:0] start_tx_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [GAP_W-1:0]  gap_o,
  output logic              cs_chg_o,
  output logic [1:0]        cs_no
);
  logic [DIV_W-1:0]  div_q;
  logic [GAP_W-1:0]  gap_q;
  logic [WORD_W-1:0] cfg2_q, rdata_q, rd_mux;
  logic [1:0]        cs_n_q;
  logic [LEN_W-1:0]  len_q;
  logic [IOW_W-1:0]  iow_q;
  logic              rd_pend_q, rvalid_q;
  logic              wr_ok, rd, data_wr_go, data_rd_go;
  logic [WORD_W-1:0] cfg_word, ctrl_word;

  assign wr_ok      = req_i && we_i && ready_i;
  assign rd         = req_i && !we_i;
  assign data_wr_go = wr_ok && (sel_i == SEL_DATA);
  assign data_rd_go = rd && (sel_i == SEL_DATA) && ready_i && (cs_n_q != 2'b11);

  assign start_o    = data_wr_go || data_rd_go;
  assign start_rd_o = data_rd_go;
  assign start_tx_o = data_wr_go ? wdata_i : '0;
  assign cs_chg_o   = wr_ok && (sel_i == SEL_CTRL) &&
                      ({wdata_i[CS1_BIT], wdata_i[CS0_BIT]} != cs_n_q);

  always_comb begin
    cfg_word = '0;
    cfg_word[DIV_LSB +: DIV_W] = div_q;
    cfg_word[GAP_LSB +: GAP_W] = gap_q;
    ctrl_word = '0;
    ctrl_word[CS0_BIT] = cs_n_q[0];
    ctrl_word[CS1_BIT] = cs_n_q[1];
    ctrl_word[LEN_LSB +: LEN_W] = len_q;
    ctrl_word[RDY_BIT] = ready_i;
    ctrl_word[IOW_LSB +: IOW_W] = iow_q;
    unique case (sel_i)
      SEL_CFG:  rd_mux = cfg_word;
      SEL_CFG2: rd_mux = cfg2_q;
      SEL_CTRL: rd_mux = ctrl_word;
      default:  rd_mux = eng_rx_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      gap_q     <= '0;
      cfg2_q    <= '0;
      cs_n_q    <= 2'b11;
      len_q     <= '0;
      iow_q     <= '0;
      rd_pend_q <= 1'b0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      if (wr_ok) begin
        unique case (sel_i)
          SEL_CFG: begin
            div_q <= wdata_i[DIV_LSB +: DIV_W];
            gap_q <= wdata_i[GAP_LSB +: GAP_W];
          end
          SEL_CFG2: cfg2_q <= wdata_i;
          SEL_CTRL: begin
            cs_n_q <= {wdata_i[CS1_BIT], wdata_i[CS0_BIT]};
            len_q  <= wdata_i[LEN_LSB +: LEN_W];
            iow_q  <= wdata_i[IOW_LSB +: IOW_W];
          end
          default: ;
        endcase
      end
      if (rd) begin
        if (data_rd_go) rd_pend_q <= 1'b1;
        else begin
          rdata_q  <= rd_mux;
          rvalid_q <= 1'b1;
        end
      end
      if (rd_pend_q && eng_done_i) begin
        rdata_q   <= eng_rx_i;
        rvalid_q  <= 1'b1;
        rd_pend_q <= 1'b0;
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign len_o    = len_q;
  assign div_o    = div_q;
  assign gap_o    = gap_q;
  assign cs_no    = cs_n_q;

  p_reg_read_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel_i != SEL_DATA) |=> rvalid_q);
  p_ctrl_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !ready_i) |=> $stable(cs_n_q));
  p_one_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q |-> !req_i);
endmodule

// File: rtl/spi_flash_shifter.sv
module spi_flash_shifter
  import spi_shf_pkg::*;
#(
  parameter int unsigned DIV_W = 3,
  parameter int unsigned GAP_W = 4,
  parameter int unsigned LEN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:2]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [1:0]        cs_no
);
  logic              ready, eng_busy, eng_done, gap_idle;
  logic              eng_start, eng_rd, cs_chg;
  logic [WORD_W-1:0] eng_tx, eng_rx;
  logic [LEN_W-1:0]  len;
  logic [DIV_W-1:0]  div;
  logic [GAP_W-1:0]  gap;

  assign ready = !eng_busy && gap_idle;

  spi_shf_regs #(.DIV_W(DIV_W), .GAP_W(GAP_W), .LEN_W(LEN_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .sel_i      (reg_sel_e'(addr_i)),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o),
    .ready_i    (ready),
    .eng_done_i (eng_done),
    .eng_rx_i   (eng_rx),
    .start_o    (eng_start),
    .start_rd_o (eng_rd),
    .start_tx_o (eng_tx),
    .len_o      (len),
    .div_o      (div),
    .gap_o      (gap),
    .cs_chg_o   (cs_chg),
    .cs_no      (cs_no)
  );

  spi_shf_gap #(.GAP_W(GAP_W)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cs_chg),
    .val_i  (gap),
    .idle_o (gap_idle)
  );

  spi_shf_engine #(.WORD_W(WORD_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .rd_i    (eng_rd),
    .len_i   (len),
    .tx_i    (eng_tx),
    .div_i   (div),
    .miso_i  (miso_i),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .rx_o    (eng_rx)
  );

  p_gap_no_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gap_idle |-> !eng_start);
  p_busy_no_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy |-> !eng_start);
endmodule

// File: tb/sim_spi_flash_shifter.sv
module sim_spi_flash_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, sclk, mosi, miso;
  logic [1:0]  cs_n;

  always #4 clk = ~clk;

  spi_flash_shifter u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  int unsigned checks = 0, fails = 0;

  // behavioural flash on select 0
  logic [63:0] pat = '0;
  logic [63:0] cap = '0;
  int unsigned idx = 0, base = 0, rise_all = 0;
  int unsigned cyc = 0, last_rise = 0, per = 0;
  logic        sclk_prev = 1'b0;

  assign miso = pat[63 - ((idx - base) % 64)];

  always @(negedge clk) begin
    cyc       <= cyc + 1;
    sclk_prev <= sclk;
    if (sclk && !sclk_prev) begin
      rise_all <= rise_all + 1;
      if (!cs_n[0]) begin
        cap       <= {cap[62:0], mosi};
        idx       <= idx + 1;
        per       <= cyc - last_rise;
        last_rise <= cyc;
      end
    end
  end

  function automatic logic [31:0] ctrl_w(input logic c0, input logic c1,
                                         input logic [1:0] len);
    return {c0, c1, len, 28'h0};
  endfunction

  function automatic logic [31:0] exp_rx(input logic [31:0] src, input int nb);
    return src & (32'hFFFF_FFFF << (32 - nb));
  endfunction

  function automatic logic [31:0] low_bits(input logic [63:0] v, input int nb);
    logic [63:0] m;
    m = (64'd1 << nb) - 64'd1;
    return 32'(v & m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    int n;
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    n = 0;
    while (!rvalid && n < 4000) begin @(negedge clk); n++; end
    d = rdata;
  endtask

  task automatic wait_rdy;
    logic [31:0] d;
    int n;
    n = 0;
    do begin rd(2'd2, d); n++; end while (!d[27] && n < 4000);
  endtask

  task automatic xfer_wr(input logic [1:0] len, input logic [31:0] d, input logic [2:0] dv);
    int nb;
    nb = (int'(len) + 1) * 8;
    wr(2'd0, {dv, 29'h0});
    base = idx;
    wr(2'd2, ctrl_w(1'b0, 1'b1, len));
    wr(2'd3, d);
    wait_rdy();
    chk("R4 tx bits", low_bits(cap, nb), d >> (32 - nb));
    chk("R4 bit count", 32'(idx - base), 32'(nb));
    chk("R5 sclk period", 32'(per), 32'(2 * (int'(dv) + 1)));
    wr(2'd2, ctrl_w(1'b1, 1'b1, len));
  endtask

  logic [31:0] last_rx = '0;

  task automatic xfer_rd(input logic [1:0] len, input logic [63:0] p, input logic [2:0] dv);
    int nb;
    logic [31:0] d;
    nb = (int'(len) + 1) * 8;
    wr(2'd0, {dv, 29'h0});
    pat = p;
    base = idx;
    wr(2'd2, ctrl_w(1'b0, 1'b1, len));
    rd(2'd3, d);
    chk("R6 rx word", d, exp_rx(p[63:32], nb));
    chk("R6 mosi low", low_bits(cap, nb), 32'h0);
    last_rx = exp_rx(p[63:32], nb);
    wr(2'd2, ctrl_w(1'b1, 1'b1, len));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (run hung) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned r0, i0;
    void'($urandom(32'h5EED_0A11));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 cs_no", {30'h0, cs_n}, 32'h3);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);
    rd(2'd2, d); chk("R1 ctrl", d, 32'hC800_0000);
    rd(2'd0, d); chk("R1 cfg", d, 32'h0);
    rd(2'd1, d); chk("R1 cfg2", d, 32'h0);

    // R2 register map
    wr(2'd1, 32'hA5A5_5A5A); rd(2'd1, d); chk("R2 cfg2", d, 32'hA5A5_5A5A);
    wr(2'd0, 32'h6280_0000); rd(2'd0, d); chk("R2 cfg fields", d, 32'h6280_0000);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'hC200_0000); rd(2'd2, d); chk("R2 width field", d, 32'hCA00_0000);
    wr(2'd2, 32'hC000_0000);

    // R3 select pins
    wr(2'd2, 32'h4000_0000); chk("R3 cs0 low", {30'h0, cs_n}, 32'h2);
    wr(2'd2, 32'h8000_0000); chk("R3 cs1 low", {30'h0, cs_n}, 32'h1);
    rd(2'd1, d);             chk("R3 cs held", {30'h0, cs_n}, 32'h1);
    wr(2'd2, 32'hC000_0000); chk("R3 both high", {30'h0, cs_n}, 32'h3);

    // R7 / R9 accesses during a burst
    wr(2'd0, 32'h6000_0000);
    base = idx;
    wr(2'd2, ctrl_w(1'b0, 1'b1, 2'd0));
    wr(2'd3, 32'h3C00_0000);
    rd(2'd2, d); chk("R7 ready low in burst", {31'h0, d[27]}, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd2, 32'hC000_0000);
    chk("R9 ctrl ignored", {30'h0, cs_n}, 32'h2);
    wait_rdy();
    chk("R9 data ignored", 32'(idx - base), 32'd8);
    chk("R4 byte", low_bits(cap, 8), 32'h3C);
    rd(2'd2, d); chk("R7 ready idle", {31'h0, d[27]}, 32'h1);
    wr(2'd2, 32'hC000_0000);

    // R8 settle window
    wr(2'd0, 32'h0280_0000);
    base = idx;
    wr(2'd2, ctrl_w(1'b0, 1'b1, 2'd0));
    wr(2'd3, 32'hAA00_0000);
    rd(2'd2, d); chk("R8 ready low after cs change", {31'h0, d[27]}, 32'h0);
    repeat (10) @(negedge clk);
    rd(2'd2, d); chk("R8 ready after settle", {31'h0, d[27]}, 32'h1);
    chk("R9 write in settle ignored", 32'(idx - base), 32'h0);
    wr(2'd2, 32'hC000_0000);
    wait_rdy();
    wr(2'd0, 32'h0);

    // R11 chained transaction
    pat = {$urandom, $urandom};
    wr(2'd0, 32'h2000_0000);
    base = idx;
    wr(2'd2, ctrl_w(1'b0, 1'b1, 2'd0));
    wr(2'd3, 32'h0B00_0000); wait_rdy();
    wr(2'd2, ctrl_w(1'b0, 1'b1, 2'd2));
    wr(2'd3, 32'h1234_5600); wait_rdy();
    wr(2'd2, ctrl_w(1'b0, 1'b1, 2'd3));
    rd(2'd3, d);
    chk("R11 read continues stream", d, pat[31:0]);
    chk("R11 header bits", cap[63:32], 32'h0B12_3456);
    chk("R11 bit total", 32'(idx - base), 32'd64);
    last_rx = pat[31:0];
    wr(2'd2, 32'hC000_0000);

    // R10 reads with nothing selected
    r0 = rise_all;
    rd(2'd3, d);
    chk("R10 last word", d, last_rx);
    chk("R10 no clock", 32'(rise_all - r0), 32'h0);

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [1:0]  ln;
      logic [2:0]  dv;
      ln = 2'($urandom_range(0, 3));
      dv = 3'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) xfer_wr(ln, $urandom, dv);
      else                           xfer_rd(ln, {$urandom, $urandom}, dv);
    end

    // directed length extremes
    xfer_rd(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0);
    xfer_rd(2'd3, 64'h8000_0001_0000_0000, 3'd7);
    xfer_wr(2'd3, 32'h8000_0001, 3'd0);
    i0 = idx;
    r0 = rise_all;
    rd(2'd3, d);
    chk("R10 repeat last", d, last_rx);
    chk("R10 idle line", 32'(idx - i0 + rise_all - r0), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule